// File: doc/BRIEF.md
# Quick DMA Channel Trigger Mapper

This block holds the control state for eight quick DMA channels. It turns an ordinary register write into a transfer request. Software points each channel at one parameter slot and at one 32-bit word inside that slot. The block watches every bus write that lands in the parameter slot window. When a write hits the word that an enabled, mapped channel points at, the block raises a request for that channel.

Requests are held in a per-channel pending flag and presented one at a time on an event port. The port carries the channel number and the slot number. It stays up until the transfer engine accepts it. When several channels wait at once, the lowest-numbered one goes first. A trigger that arrives while the same channel is still waiting is dropped and recorded in a missed flag. Enables, pending flags and missed flags are each changed by write-1 registers.

Top module: `qdma_trig_map`

## Requirements
- R1: After reset, every map register, the enable mask, the pending flags and the missed flags read as zero, and `evt_valid` is low.
- R2: Each channel ch has a map register at byte address 0x200 + 4*ch. Bits [13:5] hold the slot index and bits [4:2] hold the word index. A read returns those bits in place, and every other bit reads as zero.
- R3: A write to byte address 0x4000 + 32*slot + 4*word triggers every enabled channel whose map holds that slot and word. On the clock edge after the write, the lowest triggered channel appears as `evt_valid`=1 with its `evt_chan` and `evt_slot`. A write to any other word of the slot triggers nothing.
- R4: A trigger write that matches a disabled channel has no effect: no event, no pending flag and no missed flag.
- R5: Writing 1s to 0x108C sets enable bits and writing 1s to 0x1088 clears them. Zero bits change nothing. A read of either address returns the enable mask in bits [7:0].
- R6: A map value of zero (slot 0, word 0) means the channel is unmapped, and that channel never triggers.
- R7: An event stays on the port, with its channel and slot unchanged, until a cycle with `evt_accept` high. That accept clears the channel's pending flag at the next edge.
- R8: A trigger for a channel whose pending flag is already set is dropped and sets that channel's missed flag. This holds even if the pending event is being accepted in the same cycle.
- R9: The pending flags read at 0x1094 and the missed flags read at 0x314, in bit ch. Writing 1 to a bit at either address clears that flag. Clearing a pending flag withdraws its event.
- R10: When several channels are pending, the port shows the lowest-numbered one.
- R11: A single trigger write that matches several enabled channels makes all of them pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Bus write strobe |
| reg_addr | input | 16 | Bus byte address, used for both writes and reads |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_valid | output | 1 | A channel event is waiting for the transfer engine |
| evt_chan | output | 3 | Channel number of the presented event |
| evt_slot | output | 9 | Parameter slot mapped to that channel |
| evt_accept | input | 1 | Transfer engine takes the presented event this cycle |

## Verification
The hardest case to reach is a repeat trigger arriving in the same cycle that the engine accepts the earlier event for that channel. The channel must then end with no pending flag and a set missed flag. The stimulus reaches this with an operation that drives a slot write and `evt_accept` together. Random mappings pile several channels onto a few slots and words, so this overlap, multi-channel hits and lowest-first ordering come up often. Directed steps first walk through unmapped channels, disabled channels, wrong words and withdrawal of a pending event.

// File: rtl/qdma_trig_pkg.sv
package qdma_trig_pkg;
  // Register byte addresses; the channel map window is NUM_CH words wide
  localparam int unsigned MAP_BASE   = 32'h0000_0200;
  localparam int unsigned MISS_CLR   = 32'h0000_0314;
  localparam int unsigned EN_CLR     = 32'h0000_1088;
  localparam int unsigned EN_SET     = 32'h0000_108C;
  localparam int unsigned PEND_CLR   = 32'h0000_1094;
  localparam int unsigned SLOT_BASE  = 32'h0000_4000;
  localparam int unsigned SLOT_BYTES = 32;

  typedef enum logic [2:0] {
    AS_NONE,
    AS_MAP,
    AS_EN_SET,
    AS_EN_CLR,
    AS_PEND_CLR,
    AS_MISS_CLR,
    AS_SLOT
  } asel_e;
endpackage

// File: rtl/qdma_map_match.sv
module qdma_map_match #(
  parameter int NUM_CH = 8,
  parameter int SLOT_W = 9,
  parameter int WORD_W = 3,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int MAP_W = SLOT_W + WORD_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [CH_W-1:0]                wr_idx,
  input  logic [MAP_W-1:0]               wr_val,
  input  logic                           probe_en,
  input  logic [SLOT_W-1:0]              probe_slot,
  input  logic [WORD_W-1:0]              probe_word,
  output logic [NUM_CH-1:0][MAP_W-1:0]   maps,
  output logic [NUM_CH-1:0]              hit
);
  logic [NUM_CH-1:0][MAP_W-1:0] maps_q, maps_nxt;

  always_comb begin
    maps_nxt = maps_q;
    if (wr_en) maps_nxt[wr_idx] = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     maps_q <= '0;
    else if (wr_en) maps_q <= maps_nxt;
  end

  assign maps = maps_q;

  // One comparator per channel; zero map means unmapped
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
    assign hit[ch] = probe_en && (maps_q[ch] != '0) &&
                     (maps_q[ch] == {probe_slot, probe_word});
  end
endmodule

// File: rtl/qdma_chan_flags.sv
module qdma_chan_flags #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              pend_clr,
  input  logic              miss_clr,
  input  logic [NUM_CH-1:0] wmask,
  input  logic [NUM_CH-1:0] hit,
  input  logic [NUM_CH-1:0] acc,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] pend_q,
  output logic [NUM_CH-1:0] miss_q
);
  logic [NUM_CH-1:0] en_nxt, pend_nxt, miss_nxt, trig;
  logic [NUM_CH-1:0] set_m, clr_m, pclr_m, mclr_m;
  logic              upd;

  always_comb begin
    set_m  = en_set   ? wmask : '0;
    clr_m  = en_clr   ? wmask : '0;
    pclr_m = pend_clr ? wmask : '0;
    mclr_m = miss_clr ? wmask : '0;
    trig   = hit & en_q;
    en_nxt   = (en_q | set_m) & ~clr_m;
    pend_nxt = (pend_q & ~acc & ~pclr_m) | (trig & ~pend_q);
    miss_nxt = (miss_q & ~mclr_m) | (trig & pend_q);
    upd = en_set | en_clr | pend_clr | miss_clr | (|trig) | (|acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      miss_q <= '0;
    end else if (upd) begin
      en_q   <= en_nxt;
      pend_q <= pend_nxt;
      miss_q <= miss_nxt;
    end
  end
endmodule

// File: rtl/qdma_low_pick.sv
module qdma_low_pick #(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req,
  output logic              valid,
  output logic [CH_W-1:0]   idx,
  output logic [NUM_CH-1:0] onehot
);
  always_comb begin
    valid = |req;
    idx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) idx = CH_W'(i);
    end
  end

  assign onehot = req & (~req + NUM_CH'(1));
endmodule

// File: rtl/qdma_trig_map.sv
module qdma_trig_map
  import qdma_trig_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SLOT_W = 9,
  parameter int WORD_W = 3,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int MAP_W = SLOT_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              evt_valid,
  output logic [CH_W-1:0]   evt_chan,
  output logic [SLOT_W-1:0] evt_slot,
  input  logic              evt_accept
);
  localparam int SOFF = $clog2(SLOT_BYTES);
  localparam logic [ADDR_W-1:0] A_MAP  = ADDR_W'(MAP_BASE);
  localparam logic [ADDR_W-1:0] A_ENS  = ADDR_W'(EN_SET);
  localparam logic [ADDR_W-1:0] A_ENC  = ADDR_W'(EN_CLR);
  localparam logic [ADDR_W-1:0] A_PCL  = ADDR_W'(PEND_CLR);
  localparam logic [ADDR_W-1:0] A_MCL  = ADDR_W'(MISS_CLR);
  localparam logic [ADDR_W-1:0] A_SLOT = ADDR_W'(SLOT_BASE);
  localparam logic [ADDR_W:0]   MAP_SPAN  = (ADDR_W+1)'(NUM_CH * 4);
  localparam logic [ADDR_W:0]   SLOT_SPAN = (ADDR_W+1)'(SLOT_BYTES << SLOT_W);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sr;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= 2'b00;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_sync_n = rst_sr[1];

  // Address decode
  logic [ADDR_W-1:0] a_al, off_map, off_slot;
  asel_e             sel;
  always_comb begin
    a_al     = {reg_addr[ADDR_W-1:2], 2'b00};
    off_map  = a_al - A_MAP;
    off_slot = a_al - A_SLOT;
    if ((a_al >= A_MAP) && ({1'b0, off_map} < MAP_SPAN))          sel = AS_MAP;
    else if (a_al == A_ENS)                                       sel = AS_EN_SET;
    else if (a_al == A_ENC)                                       sel = AS_EN_CLR;
    else if (a_al == A_PCL)                                       sel = AS_PEND_CLR;
    else if (a_al == A_MCL)                                       sel = AS_MISS_CLR;
    else if ((a_al >= A_SLOT) && ({1'b0, off_slot} < SLOT_SPAN)) sel = AS_SLOT;
    else                                                          sel = AS_NONE;
  end

  logic [CH_W-1:0]              map_idx;
  logic [NUM_CH-1:0][MAP_W-1:0] maps;
  logic [NUM_CH-1:0]            hit, en_q, pend_q, miss_q, pk_onehot, acc;
  logic                         pk_valid;
  logic [CH_W-1:0]              pk_idx;

  assign map_idx = off_map[2 +: CH_W];

  qdma_map_match #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (reg_wr && (sel == AS_MAP)),
    .wr_idx     (map_idx),
    .wr_val     (reg_wdata[2 +: MAP_W]),
    .probe_en   (reg_wr && (sel == AS_SLOT)),
    .probe_slot (off_slot[SOFF +: SLOT_W]),
    .probe_word (off_slot[2 +: WORD_W]),
    .maps       (maps),
    .hit        (hit)
  );

  qdma_chan_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_set   (reg_wr && (sel == AS_EN_SET)),
    .en_clr   (reg_wr && (sel == AS_EN_CLR)),
    .pend_clr (reg_wr && (sel == AS_PEND_CLR)),
    .miss_clr (reg_wr && (sel == AS_MISS_CLR)),
    .wmask    (reg_wdata[NUM_CH-1:0]),
    .hit      (hit),
    .acc      (acc),
    .en_q     (en_q),
    .pend_q   (pend_q),
    .miss_q   (miss_q)
  );

  qdma_low_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req    (pend_q),
    .valid  (pk_valid),
    .idx    (pk_idx),
    .onehot (pk_onehot)
  );

  assign acc       = (evt_accept && pk_valid) ? pk_onehot : '0;
  assign evt_valid = pk_valid;
  assign evt_chan  = pk_idx;
  assign evt_slot  = maps[pk_idx][WORD_W +: SLOT_W];

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (sel)
      AS_MAP:               reg_rdata = DATA_W'({maps[map_idx], 2'b00});
      AS_EN_SET, AS_EN_CLR: reg_rdata = DATA_W'(en_q);
      AS_PEND_CLR:          reg_rdata = DATA_W'(pend_q);
      AS_MISS_CLR:          reg_rdata = DATA_W'(miss_q);
      default:              reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/qdma_trig_map_chk.sv
module qdma_trig_map_chk #(
  parameter int NUM_CH = 8,
  parameter int SLOT_W = 9,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              evt_valid,
  input logic              evt_accept,
  input logic [CH_W-1:0]   evt_chan,
  input logic [SLOT_W-1:0] evt_slot,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] pend_q,
  input logic [NUM_CH-1:0] miss_q
);
  logic [NUM_CH-1:0] below;
  assign below = (NUM_CH'(1) << evt_chan) - NUM_CH'(1);

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> !evt_valid);

  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~$past(pend_q) & ~$past(en_q)) == '0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_accept && !reg_wr) |=>
      (evt_valid && $stable(evt_chan) && $stable(evt_slot)));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_accept) |=> !pend_q[$past(evt_chan)]);

  p_miss_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((miss_q & ~$past(miss_q)) != '0) |-> $past(reg_wr));

  p_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (pend_q[evt_chan] && ((pend_q & below) == '0)));
endmodule

bind qdma_trig_map qdma_trig_map_chk #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_wr     (reg_wr),
  .evt_valid  (evt_valid),
  .evt_accept (evt_accept),
  .evt_chan   (evt_chan),
  .evt_slot   (evt_slot),
  .en_q       (en_q),
  .pend_q     (pend_q),
  .miss_q     (miss_q)
);

// File: tb/qdma_trig_map_tb.sv
module qdma_trig_map_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        evt_valid;
  logic [2:0]  evt_chan;
  logic [8:0]  evt_slot;
  logic        evt_accept;

  int n_chk = 0;
  int n_err = 0;

  logic [11:0] m_map [8];
  logic [7:0]  m_en, m_pend, m_miss;

  always #2 clk = ~clk;

  qdma_trig_map u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_valid(evt_valid),
    .evt_chan(evt_chan), .evt_slot(evt_slot), .evt_accept(evt_accept)
  );

  function automatic int lowest(input logic [7:0] v);
    int r = -1;
    for (int i = 7; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [15:0] slot_addr(input int slot, input int word);
    return 16'(32'h4000 + slot * 32 + word * 4);
  endfunction

  function automatic logic [31:0] map_val(input int slot, input int word);
    return 32'((slot << 5) | (word << 2));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [15:0] a, input logic [31:0] d, input logic acc);
    logic [15:0] al;
    logic [7:0]  trig, accm, wm, pclr, mclr;
    int l;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; evt_accept = acc;
    al = {a[15:2], 2'b00};
    wm = d[7:0];
    l = lowest(m_pend);
    accm = (acc && l >= 0) ? 8'(1 << l) : 8'h00;
    trig = '0; pclr = '0; mclr = '0;
    if (wr) begin
      if (al >= 16'h0200 && al < 16'h0220) m_map[al[4:2]] = d[13:2];
      else if (al == 16'h108C) m_en = m_en | wm;
      else if (al == 16'h1088) m_en = m_en & ~wm;
      else if (al == 16'h1094) pclr = wm;
      else if (al == 16'h0314) mclr = wm;
      else if (al >= 16'h4000 && al < 16'h8000) begin
        for (int i = 0; i < 8; i++)
          if (m_en[i] && m_map[i] != 12'h0 && m_map[i] == {al[13:5], al[4:2]}) trig[i] = 1'b1;
      end
    end
    m_miss = (m_miss & ~mclr) | (trig & m_pend);
    m_pend = (m_pend & ~accm & ~pclr) | (trig & ~m_pend);
    @(negedge clk);
    reg_wr = 1'b0; evt_accept = 1'b0; reg_addr = 16'h0; reg_wdata = '0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_op(1'b1, a, d, 1'b0);
  endtask

  task automatic accept();
    bus_op(1'b0, 16'h0, 32'h0, 1'b1);
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic chk_evt(input string req);
    int l;
    l = lowest(m_pend);
    chk({req, " evt_valid"}, 32'(evt_valid), 32'(l >= 0));
    if (l >= 0) begin
      chk({req, " evt_chan"}, 32'(evt_chan), 32'(l));
      chk({req, " evt_slot"}, 32'(evt_slot), 32'(m_map[l][11:3]));
    end
  endtask

  task automatic chk_status(input string req);
    for (int c = 0; c < 8; c++) rd_chk({req, " map"}, 16'(32'h200 + c * 4), {18'h0, m_map[c], 2'b00});
    rd_chk({req, " enable"}, 16'h108C, {24'h0, m_en});
    rd_chk({req, " enable"}, 16'h1088, {24'h0, m_en});
    rd_chk({req, " pending"}, 16'h1094, {24'h0, m_pend});
    rd_chk({req, " missed"}, 16'h0314, {24'h0, m_miss});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int op, c;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) m_map[i] = '0;
    m_en = '0; m_pend = '0; m_miss = '0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; evt_accept = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk_evt("R1");
    chk_status("R1");

    // R2 map readback with junk bits outside the fields
    wr(16'h0208, map_val(5, 7) | 32'hFFFF_C003);
    rd_chk("R2", 16'h0208, map_val(5, 7));
    // R4 disabled channel ignores its trigger
    wr(slot_addr(5, 7), 32'h1);
    chk_evt("R4");
    rd_chk("R4 pending", 16'h1094, 32'h0);
    rd_chk("R4 missed", 16'h0314, 32'h0);
    // R5 enable set, zero bits do nothing
    wr(16'h108C, 32'h04);
    wr(16'h108C, 32'h00);
    rd_chk("R5", 16'h108C, 32'h04);
    rd_chk("R5", 16'h1088, 32'h04);
    // R3 trigger
    wr(slot_addr(5, 7), 32'h0);
    chk_evt("R3");
    chk("R3 chan", 32'(evt_chan), 32'd2);
    rd_chk("R9 pending", 16'h1094, 32'h04);
    // R8 repeat trigger while pending
    wr(slot_addr(5, 7), 32'h0);
    rd_chk("R8", 16'h0314, 32'h04);
    chk_evt("R8");
    // R7 accept
    accept();
    chk("R7 valid", 32'(evt_valid), 32'd0);
    rd_chk("R7 pending", 16'h1094, 32'h0);
    // R9 missed clear
    wr(16'h0314, 32'h04);
    rd_chk("R9", 16'h0314, 32'h0);
    // R3 wrong word in mapped slot
    wr(slot_addr(5, 6), 32'h0);
    chk("R3 wrong word", 32'(evt_valid), 32'd0);
    // R6 zero map never triggers
    wr(16'h0200, 32'h0);
    wr(16'h108C, 32'h01);
    wr(slot_addr(0, 0), 32'h0);
    chk("R6", 32'(evt_valid), 32'd0);
    // R11 and R10: two channels on one word
    wr(16'h0218, map_val(9, 1));
    wr(16'h020C, map_val(9, 1));
    wr(16'h108C, 32'h48);
    wr(slot_addr(9, 1), 32'h0);
    rd_chk("R11", 16'h1094, 32'h48);
    chk("R10 first", 32'(evt_chan), 32'd3);
    accept();
    chk("R10 second", 32'(evt_chan), 32'd6);
    chk_evt("R10");
    accept();
    chk_evt("R7");
    // R9 pending clear withdraws the event
    wr(slot_addr(5, 7), 32'h0);
    chk_evt("R9");
    wr(16'h1094, 32'h04);
    chk("R9 withdraw", 32'(evt_valid), 32'd0);
    // R8 repeat trigger during accept of the same channel
    wr(slot_addr(5, 7), 32'h0);
    bus_op(1'b1, slot_addr(5, 7), 32'h0, 1'b1);
    rd_chk("R8 pending", 16'h1094, 32'h0);
    rd_chk("R8 missed", 16'h0314, 32'h04);
    // R5 enable clear stops triggering
    wr(16'h1088, 32'h04);
    rd_chk("R5", 16'h108C, 32'h49);
    wr(slot_addr(5, 7), 32'h0);
    chk_evt("R5");

    // Random phase
    for (int it = 0; it < 500; it++) begin
      op = int'($urandom % 10);
      case (op)
        0: begin
          c = int'($urandom % 8);
          if ($urandom % 5 == 0) wr(16'(32'h200 + c * 4), $urandom & 32'hFFFF_C003);
          else wr(16'(32'h200 + c * 4), map_val(int'($urandom % 4), int'($urandom % 8)) | ($urandom & 32'hFFFF_C003));
        end
        1: wr(16'h108C, $urandom);
        2: wr(16'h1088, $urandom & $urandom);
        3, 4, 5: wr(slot_addr(int'($urandom % 4), int'($urandom % 8)), $urandom);
        6: accept();
        7: bus_op(1'b1, slot_addr(int'($urandom % 4), int'($urandom % 8)), 32'h0, 1'b1);
        8: wr(($urandom % 2 == 0) ? 16'h1094 : 16'h0314, $urandom & $urandom);
        default: wr(($urandom % 2 == 0) ? 16'h1000 : slot_addr(int'(4 + $urandom % 8), 0), $urandom);
      endcase
      chk_evt("R10 random");
      if (it % 16 == 15) chk_status("R9 random");
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule